// File: doc/BRIEF.md
# Free-Running-Prescaler SPI Master

This block is a byte-wide SPI master whose serial clock comes from a prescaler that counts continuously. The prescaler does not restart when the CPU writes data. A write into the data holding register asks for a transfer. The shift engine loads that byte only at the next bit-period boundary of the prescaler. The start delay therefore depends on where the write lands in the prescaler phase, and it is never longer than one bit time. The prescaler counts only while both the enable input and the master-select input are high. When either is low, the prescaler is held, any buffered byte is discarded and any transfer is dropped.

Each transfer shifts eight bits MSB first on `mosi` and collects eight bits from `miso`. Clock polarity and phase are set by two inputs. When the eighth bit ends, `sck` goes back to its idle level. The received byte then appears on `rx_data`, together with a one-cycle `done` pulse. A byte written while a transfer is running waits in the holding register. It starts at the boundary where the current byte ends, so there is no gap between the two bytes. If several bytes are written during one transfer, the last one is the byte sent next.

Top module: `spi_fr_master`

## Requirements
- R1: After reset, `sck` equals `cpol`, `mosi` is 0, `done` is 0 and `rx_data` is 0.
- R2: A bit time is DIV cycles, with DIV = 2, 8, 32, 128 for `rate` = 0, 1, 2, 3. A transfer makes exactly 16 `sck` transitions.
- R3: Let edge W be the clock edge that accepts the write. `done` is observed after edge W+k, with k between 8·DIV+1 and 9·DIV. The value of k depends only on the prescaler phase at the write, and every value in that range can occur.
- R4: `mosi` carries the byte MSB first. It changes only at bit boundaries, so it is stable across the mid-bit `sck` transition.
- R5: `miso` is sampled on the first `sck` transition of each bit when `cpha`=0 and on the second transition when `cpha`=1. The sampled bits, MSB first, form `rx_data`.
- R6: With `cpha`=0, `sck` holds its idle level for the first half bit, so the first transition comes 8·DIV−DIV/2 cycles before `done`. With `cpha`=1, the first transition is from idle to active and starts the first bit, 8·DIV cycles before `done`.
- R7: Outside a transfer, `sck` equals `cpol`. After the last bit it goes back to that level.
- R8: `done` is high for exactly one cycle per byte. `rx_data` takes the new byte in the same cycle.
- R9: A byte written during a transfer is sent right after it. The second `done` comes exactly 8·DIV cycles after the first. If several writes occur during one transfer, the last write wins.
- R10: While `en` or `master` is low, writes are ignored, the prescaler is halted and no `sck` activity or `done` occurs. Re-enabling does not send a byte that was written earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| master | input | 1 | Master-mode select |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | Clock phase: 0 samples on the first transition of a bit, 1 on the second |
| rate | input | 2 | Bit-time select (DIV = 2, 8, 32, 128) |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to send |
| miso | input | 1 | Serial input from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the slave |
| done | output | 1 | One-cycle byte-complete pulse |
| rx_data | output | 8 | Last received byte |

## Verification
The write-accepting edge is taken as cycle 0. A single transfer's `done` must then appear within the window of R3. The first `sck` transition must come exactly 8·DIV or 8·DIV−DIV/2 cycles before `done`, depending on phase. A back-to-back byte must complete exactly 8·DIV cycles after the previous one. Outputs are sampled on the falling clock edge, and cycle numbers come from a counter that advances on the rising edge. Each check therefore compares whole edge counts against these arithmetic windows. A sweep of eight write offsets at DIV=8 must hit both ends of the start-latency window. The serial bit streams are captured at the mid-bit `sck` transitions, where `mosi` and `miso` are guaranteed stable.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;
    localparam int DW      = 8;                 // bits per transfer
    localparam int NRATE_W = 2;                 // rate select width
    localparam int PRE_W   = 2 * ((1 << NRATE_W) - 1) + 1; // prescaler bits, covers the slowest rate
    localparam int NEDGE   = 2 * DW;            // half periods per byte
    localparam int EDGE_W  = $clog2(NEDGE);

    typedef logic [NRATE_W-1:0] rate_t;
    typedef logic [DW-1:0]      byte_t;
    typedef logic [EDGE_W-1:0]  edge_t;

    typedef struct packed {
        logic bit_end;   // last cycle of a bit period
        logic half_end;  // last cycle of a half period
    } tick_t;

    // low-order ones mask marking one full bit period of the prescaler
    function automatic logic [PRE_W-1:0] bit_mask(input rate_t r);
        logic [PRE_W:0] w;
        w = ((PRE_W+1)'(1) << (2 * int'(r) + 1)) - (PRE_W+1)'(1);
        return w[PRE_W-1:0];
    endfunction

    function automatic logic [PRE_W-1:0] half_mask(input rate_t r);
        return bit_mask(r) >> 1;
    endfunction
endpackage

// File: rtl/spi_fr_prescaler.sv
module spi_fr_prescaler
    import spi_fr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  rate_t rate,
    output tick_t tick
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        tick.bit_end  = run && (&(cnt_q | ~bit_mask(rate)));
        tick.half_end = run && (&(cnt_q | ~half_mask(rate)));
    end

    // every bit boundary is also a half boundary
    p_bit_is_half_r2: assert property (@(posedge clk) disable iff (rst)
        tick.bit_end |-> tick.half_end);

    // halted prescaler produces no ticks one cycle later
    p_halt_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!run || !tick.bit_end));
endmodule

// File: rtl/spi_fr_engine.sv
module spi_fr_engine
    import spi_fr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  tick_t tick,
    input  logic  cpha,
    input  logic  start,
    input  byte_t load_data,
    input  logic  miso,
    output logic  busy,
    output logic  last,
    output logic  phase,
    output logic  mosi,
    output logic  done,
    output byte_t rx_data
);
    localparam edge_t EDGE_LAST = edge_t'(NEDGE - 1);

    logic  busy_q, phase_q, done_q;
    edge_t edge_q;
    byte_t tx_q, rxs_q, rx_q;

    assign last = busy_q && tick.half_end && (edge_q == EDGE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
            edge_q  <= '0;
            tx_q    <= '0;
            rxs_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q && tick.half_end) begin
                if (!edge_q[0]) rxs_q <= {rxs_q[DW-2:0], miso}; // mid-bit sample
                else            tx_q  <= {tx_q[DW-2:0], 1'b0};  // bit boundary shift
                edge_q  <= edge_q + 1'b1;
                phase_q <= ~phase_q;
                if (last) begin
                    busy_q  <= 1'b0;
                    phase_q <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
            if (start) begin
                busy_q  <= 1'b1;
                edge_q  <= '0;
                phase_q <= cpha;
                tx_q    <= load_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      rx_q <= '0;
        else if (run && last)         rx_q <= rxs_q;
    end

    assign busy    = busy_q;
    assign phase   = phase_q;
    assign mosi    = busy_q ? tx_q[DW-1] : 1'b0;
    assign done    = done_q;
    assign rx_data = rx_q;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_phase_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !phase_q);

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        run && busy_q && !tick.half_end && !start |=> $stable(edge_q));

    p_mosi_mid_r4: assert property (@(posedge clk) disable iff (rst)
        run && busy_q && tick.half_end && !edge_q[0] && !start |=> $stable(mosi));
endmodule

// File: rtl/spi_fr_master.sv
module spi_fr_master
    import spi_fr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       master,
    input  logic       cpol,
    input  logic       cpha,
    input  logic [1:0] rate,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_data
);
    logic  run, busy, last, phase, start, buf_full_q;
    byte_t buf_q;
    tick_t tick;

    assign run   = en && master;
    assign start = tick.bit_end && buf_full_q && (!busy || last);

    spi_fr_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .rate (rate_t'(rate)),
        .tick (tick)
    );

    // holding register: later write in the same cycle as a start wins
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            buf_full_q <= 1'b0;
            buf_q      <= '0;
        end else begin
            if (start) buf_full_q <= 1'b0;
            if (wr_en) begin
                buf_full_q <= 1'b1;
                buf_q      <= wr_data;
            end
        end
    end

    spi_fr_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .cpha      (cpha),
        .start     (start),
        .load_data (buf_q),
        .miso      (miso),
        .busy      (busy),
        .last      (last),
        .phase     (phase),
        .mosi      (mosi),
        .done      (done),
        .rx_data   (rx_data)
    );

    assign sck = cpol ^ phase;

    p_start_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick.bit_end));

    p_write_held_r9: assert property (@(posedge clk) disable iff (rst)
        run && wr_en |=> (!run || buf_full_q));

    p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!busy && !buf_full_q) || run);
endmodule

// File: tb/spi_fr_master_test.sv
`timescale 1ns/1ps
module spi_fr_master_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, master = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic [1:0] rate = 2'd0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic miso;
    logic sck, mosi, done;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    int edge_n = 0, idx = 0, first_cyc = 0;
    logic [7:0] s_byte = 8'h00, mosi_cap = 8'h00;
    int done_cnt = 0;

    always #4 clk = ~clk;

    spi_fr_master uut (
        .clk(clk), .rst(rst), .en(en), .master(master), .cpol(cpol), .cpha(cpha),
        .rate(rate), .wr_en(wr_en), .wr_data(wr_data), .miso(miso),
        .sck(sck), .mosi(mosi), .done(done), .rx_data(rx_data)
    );

    always @(posedge clk) cyc = cyc + 1;
    always @(negedge clk) if (done) done_cnt = done_cnt + 1;

    // slave model and MOSI capture at the mid-bit transitions
    always @(sck) begin
        if (mon_on) begin
            edge_n = edge_n + 1;
            if (edge_n == 1) first_cyc = cyc;
            if (!cpha) begin
                if (edge_n % 2 == 1) mosi_cap = {mosi_cap[6:0], mosi};
                else                 idx = (edge_n / 2) % 8;
            end else begin
                if (edge_n % 2 == 1) idx = ((edge_n - 1) / 2) % 8;
                else                 mosi_cap = {mosi_cap[6:0], mosi};
            end
        end
    end
    always_comb miso = s_byte[7 - idx];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic wait_done(output int dcyc, output bit ok);
        ok = 1'b0; dcyc = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; dcyc = cyc; break; end
        end
    endtask

    task automatic xfer(input int r, input bit pol, input bit ph, input logic [7:0] tx,
                        input logic [7:0] sb, input int gap, output int lat);
        int div, wcyc, dcyc; bit ok;
        div = 2 << (2 * r);
        mon_on = 1'b0;
        @(negedge clk);
        rate = 2'(r); cpol = pol; cpha = ph; s_byte = sb;
        edge_n = 0; idx = 0; mosi_cap = 8'h00;
        @(negedge clk);
        mon_on = 1'b1;
        for (int g = 0; g < gap; g++) @(negedge clk);
        wr_en = 1'b1; wr_data = tx; wcyc = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_done(dcyc, ok);
        chk(ok, "R3", "done seen", int'(ok), 1);
        lat = dcyc - wcyc;
        chk(lat >= 8*div+1 && lat <= 9*div, "R3", "write-to-done cycles", lat, 8*div+1);
        chk(rx_data == sb, "R5", "rx_data", int'(rx_data), int'(sb));
        chk(mosi_cap == tx, "R4", "mosi byte", int'(mosi_cap), int'(tx));
        chk(dcyc - first_cyc == (ph ? 8*div : 8*div - div/2), "R6", "first sck to done",
            dcyc - first_cyc, ph ? 8*div : 8*div - div/2);
        @(negedge clk);
        chk(!done, "R8", "done width", int'(done), 0);
        chk(edge_n == 16, "R2", "sck transitions", edge_n, 16);
        chk(sck == pol, "R7", "sck idle after byte", int'(sck), int'(pol));
    endtask

    initial begin
        int lat, lmin, lmax, d1, d2, dc0; bit ok;
        logic [7:0] tx;
        repeat (3) @(negedge clk);
        chk(sck == 1'b0 && mosi == 1'b0, "R1", "sck/mosi after reset", int'({sck, mosi}), 0);
        chk(done == 1'b0 && rx_data == 8'h00, "R1", "done/rx after reset", int'({done, rx_data}), 0);
        rst = 1'b0;
        en = 1'b1; master = 1'b1;

        // full sweep of rate, polarity and phase
        for (int r = 0; r < 4; r++)
            for (int pol = 0; pol < 2; pol++)
                for (int ph = 0; ph < 2; ph++) begin
                    tx = 8'(8'hA5 ^ (r * 37 + pol * 3 + ph * 91));
                    xfer(r, pol[0], ph[0], tx, ~{tx[3:0], tx[7:4]}, r + ph, lat);
                end

        // start-latency sweep over all write offsets at DIV=8 (R3)
        lmin = 1000; lmax = 0;
        for (int k = 0; k < 8; k++) begin
            xfer(1, 1'b0, k[0], 8'(8'h30 + k), 8'(8'hC0 + k), k, lat);
            if (lat < lmin) lmin = lat;
            if (lat > lmax) lmax = lat;
        end
        chk(lmin == 65, "R3", "shortest latency", lmin, 65);
        chk(lmax == 72, "R3", "longest latency", lmax, 72);

        // back-to-back with overwrite during transfer (R9), DIV=8
        mon_on = 1'b0;
        @(negedge clk);
        rate = 2'd1; cpol = 1'b0; cpha = 1'b0; s_byte = 8'h96;
        edge_n = 0; idx = 0; mosi_cap = 8'h00;
        @(negedge clk);
        mon_on = 1'b1;
        dc0 = done_cnt;
        wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk); wr_en = 1'b0;
        repeat (12) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h22;
        @(negedge clk); wr_data = 8'h3C;
        @(negedge clk); wr_en = 1'b0;
        wait_done(d1, ok);
        chk(ok, "R9", "first done", int'(ok), 1);
        @(negedge clk);
        wait_done(d2, ok);
        chk(ok, "R9", "second done", int'(ok), 1);
        chk(d2 - d1 == 64, "R9", "gap between bytes", d2 - d1, 64);
        chk(mosi_cap == 8'h3C, "R9", "last write sent", int'(mosi_cap), 8'h3C);
        chk(rx_data == 8'h96, "R5", "rx back-to-back", int'(rx_data), 8'h96);
        repeat (200) @(negedge clk);
        chk(done_cnt - dc0 == 2, "R8", "done count", done_cnt - dc0, 2);

        // disabled modes (R10)
        for (int m = 0; m < 2; m++) begin
            mon_on = 1'b0;
            @(negedge clk);
            en = m[0]; master = ~m[0]; cpol = 1'b1; rate = 2'd0;
            edge_n = 0;
            @(negedge clk);
            mon_on = 1'b1;
            dc0 = done_cnt;
            wr_en = 1'b1; wr_data = 8'hE7;
            @(negedge clk); wr_en = 1'b0;
            repeat (100) @(negedge clk);
            chk(done_cnt == dc0 && edge_n == 0, "R10", "no activity while off",
                done_cnt - dc0 + edge_n, 0);
            chk(sck == 1'b1, "R10", "sck idle while off", int'(sck), 1);
            en = 1'b1; master = 1'b1;
            repeat (100) @(negedge clk);
            chk(done_cnt == dc0 && edge_n == 0, "R10", "stale byte dropped",
                done_cnt - dc0 + edge_n, 0);
        end

        finish_run();
    end
endmodule